// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Responder

This block imitates a small serial EEPROM of 16-bit words that is reached over the common three-wire-plus-select serial bus (select, clock, data in, data out). It samples the bus pins with the chip's own fast clock and watches for rising edges of the serial clock. While select is high it waits for a start bit, then collects a two-bit opcode and a word address, and, for the write commands, sixteen data bits. It keeps its words in an internal register array. All cells come out of reset in the erased state.

Reads answer on the data-out pin. Programming commands alter the array only while an internal write-enable latch is set. A short fixed busy window follows each programming operation. The block can be placed on chip as a boot-parameter target, or next to a bus master as a partner that checks that master's traffic.

Top module: `mw_eeprom_responder`

## Requirements
- R1: After reset every word reads 0xFFFF, the write-enable latch is clear and data out is low.
- R2: A frame begins at the first rising serial-clock edge that samples data in high while select is high. Zeros clocked in before that edge are ignored.
- R3: Opcode 2'b10 (read) drives data out low from the edge of the last address bit. Each following rising edge presents one bit of the stored word, most significant bit first, for 16 edges. The next edge returns data out to low.
- R4: Opcode 2'b01 (write), with the latch set, stores the 16 data bits that follow the address into that word. Every other word is left unchanged.
- R5: Opcode 2'b11 (erase), with the latch set, sets the addressed word to 0xFFFF. The other words are left unchanged.
- R6: Opcode 2'b00 with the two address MSBs at 2'b11 sets the write-enable latch, and with them at 2'b00 clears it. While the latch is clear, write, erase and both bulk commands leave every word unchanged.
- R7: Opcode 2'b00 with the two address MSBs at 2'b10, with the latch set, sets every word to 0xFFFF.
- R8: Opcode 2'b00 with the two address MSBs at 2'b01, with the latch set, stores the 16 data bits that follow in every word.
- R9: Select low ends any frame. Data out goes low, and a frame cut short before its last data bit changes no word.
- R10: For BUSY_CYCLES clock cycles after a programming operation, a frame whose start bit arrives is discarded until select falls. Data out stays low through it and no command in it acts.
- R11: Data out is low whenever no read answer is being shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| mw_cs | input | 1 | Serial chip select, active high |
| mw_sk | input | 1 | Serial clock from the bus master |
| mw_di | input | 1 | Serial data into the responder |
| mw_do | output | 1 | Serial data out of the responder |

## Verification
The busy window is the hardest case to reach from the pins. It only exists for a few dozen system cycles after a programming edge, and a command must start inside it. The stimulus ends a write frame, drops select for a handful of cycles, and starts a read of the same word at once, so that the start bit lands inside the window. It then expects data out to stay low for the whole frame. After the window has passed, the same read must return the newly written word. The cut-short frames are timed the same way: select falls partway through a data field or a read answer, and the bench then checks the word and the data-out level.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } mw_op_e;

  typedef enum logic [1:0] {
    EXT_LOCK   = 2'b00,
    EXT_FILL   = 2'b01,
    EXT_CLEAR  = 2'b10,
    EXT_UNLOCK = 2'b11
  } mw_ext_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_READ,
    ST_DONE
  } mw_state_e;

endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic cs_o,
  output logic di_o,
  output logic sk_rise_o
);

  logic [STAGES-1:0] cs_q, sk_q, di_q;
  logic [STAGES-1:0] cs_n, sk_n, di_n;
  logic              sk_prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_comb begin
        cs_n = cs_i;
        sk_n = sk_i;
        di_n = di_i;
      end
    end else begin : g_chain
      always_comb begin
        cs_n = {cs_q[STAGES-2:0], cs_i};
        sk_n = {sk_q[STAGES-2:0], sk_i};
        di_n = {di_q[STAGES-2:0], di_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q      <= '0;
      sk_q      <= '0;
      di_q      <= '0;
      sk_prev_q <= 1'b0;
    end else begin
      cs_q      <= cs_n;
      sk_q      <= sk_n;
      di_q      <= di_n;
      sk_prev_q <= sk_q[STAGES-1];
    end
  end

  assign cs_o      = cs_q[STAGES-1];
  assign di_o      = di_q[STAGES-1];
  assign sk_rise_o = sk_q[STAGES-1] & ~sk_prev_q;

  p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sk_rise_o |=> !sk_rise_o);

endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              wr_all_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [WORDS];

  generate
    for (genvar i = 0; i < WORDS; i++) begin : g_word
      logic hit;
      logic [DATA_W-1:0] mem_n;

      always_comb begin
        hit   = wr_en_i && (wr_all_i || (wr_addr_i == ADDR_W'(i)));
        mem_n = wr_data_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem_q[i] <= '1;
        end else if (hit) begin
          mem_q[i] <= mem_n;
        end
      end

      p_hold_without_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(mem_q[i]));

      p_other_words_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_all_i && (wr_addr_i != ADDR_W'(i))) |=> $stable(mem_q[i]));

      p_bulk_reaches_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_all_i) |=> (mem_q[i] == $past(wr_data_i)));
    end
  endgenerate

  assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/mw_decoder.sv
module mw_decoder
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              di_i,
  input  logic              sk_rise_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic              wr_all_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              do_o
);

  localparam int MAXN   = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CNT_W  = $clog2(MAXN + 1);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

  mw_state_e         state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [1:0]        op_q, op_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic              wen_q, wen_n;
  logic              do_q, do_n;
  logic [BUSY_W-1:0] busy_q, busy_n;
  logic [DATA_W-1:0] word;
  logic [1:0]        ext_sel;

  always_comb begin
    state_n   = state_q;
    cnt_n     = cnt_q;
    op_n      = op_q;
    addr_n    = addr_q;
    data_n    = data_q;
    wen_n     = wen_q;
    do_n      = do_q;
    busy_n    = (busy_q != '0) ? busy_q - 1'b1 : busy_q;
    wr_en_o   = 1'b0;
    wr_all_o  = 1'b0;
    wr_data_o = '1;
    word      = '0;
    ext_sel   = '0;

    if (!cs_i) begin
      state_n = ST_IDLE;
      cnt_n   = '0;
      do_n    = 1'b0;
    end else if (sk_rise_i) begin
      case (state_q)
        ST_IDLE: begin
          if (di_i) begin
            cnt_n   = '0;
            state_n = (busy_q != '0) ? ST_DONE : ST_OPC;
          end
        end
        ST_OPC: begin
          op_n  = {op_q[0], di_i};
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(1)) begin
            cnt_n   = '0;
            state_n = ST_ADDR;
          end
        end
        ST_ADDR: begin
          addr_n  = {addr_q[ADDR_W-2:0], di_i};
          cnt_n   = cnt_q + 1'b1;
          ext_sel = addr_n[ADDR_W-1 -: 2];
          if (cnt_q == CNT_W'(ADDR_W - 1)) begin
            cnt_n   = '0;
            state_n = ST_DONE;
            case (mw_op_e'(op_q))
              OP_READ: begin
                state_n = ST_READ;
                do_n    = 1'b0;
              end
              OP_WRITE: state_n = ST_DATA;
              OP_ERASE: begin
                if (wen_q) begin
                  wr_en_o = 1'b1;
                  busy_n  = BUSY_W'(BUSY_CYCLES);
                end
              end
              default: begin
                case (mw_ext_e'(ext_sel))
                  EXT_UNLOCK: wen_n   = 1'b1;
                  EXT_LOCK:   wen_n   = 1'b0;
                  EXT_FILL:   state_n = ST_DATA;
                  default: begin
                    if (wen_q) begin
                      wr_en_o  = 1'b1;
                      wr_all_o = 1'b1;
                      busy_n   = BUSY_W'(BUSY_CYCLES);
                    end
                  end
                endcase
              end
            endcase
          end
        end
        ST_DATA: begin
          data_n = {data_q[DATA_W-2:0], di_i};
          cnt_n  = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(DATA_W - 1)) begin
            state_n   = ST_DONE;
            wr_data_o = data_n;
            if (wen_q) begin
              wr_en_o  = 1'b1;
              wr_all_o = (op_q == OP_EXT);
              busy_n   = BUSY_W'(BUSY_CYCLES);
            end
          end
        end
        ST_READ: begin
          word   = (cnt_q == '0) ? rd_data_i : data_q;
          do_n   = word[DATA_W-1];
          data_n = {word[DATA_W-2:0], 1'b0};
          cnt_n  = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(DATA_W)) begin
            do_n    = 1'b0;
            state_n = ST_DONE;
          end
        end
        default: state_n = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      op_q    <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      wen_q   <= 1'b0;
      do_q    <= 1'b0;
      busy_q  <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      op_q    <= op_n;
      addr_q  <= addr_n;
      data_q  <= data_n;
      wen_q   <= wen_n;
      do_q    <= do_n;
      busy_q  <= busy_n;
    end
  end

  assign rd_addr_o = addr_q;
  assign wr_addr_o = addr_n;
  assign do_o      = do_q;

  p_cs_low_quiets_do_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_i |=> !do_o);

  p_busy_discards_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && sk_rise_i && di_i && (state_q == ST_IDLE) && (busy_q != '0))
      |=> (state_q == ST_DONE));

  p_read_tail_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && sk_rise_i && (state_q == ST_READ) && (cnt_q == CNT_W'(DATA_W)))
      |=> (!do_o && (state_q == ST_DONE)));

  p_latch_moves_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sk_rise_i |=> $stable(wen_q));

  p_quiet_outside_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_READ) && (state_q != ST_DONE) |-> !do_o);

endmodule

// File: rtl/mw_eeprom_responder.sv
module mw_eeprom_responder #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mw_cs,
  input  logic mw_sk,
  input  logic mw_di,
  output logic mw_do
);

  logic              rst_meta_q, rst_n_sync;
  logic              cs_s, di_s, sk_rise;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en, wr_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_sync <= rst_meta_q;
    end
  end

  mw_pin_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .cs_i      (mw_cs),
    .sk_i      (mw_sk),
    .di_i      (mw_di),
    .cs_o      (cs_s),
    .di_o      (di_s),
    .sk_rise_o (sk_rise)
  );

  mw_decoder #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_dec (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .cs_i      (cs_s),
    .di_i      (di_s),
    .sk_rise_i (sk_rise),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .wr_en_o   (wr_en),
    .wr_all_o  (wr_all),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .do_o      (mw_do)
  );

  mw_word_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .wr_en_i   (wr_en),
    .wr_all_i  (wr_all),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

endmodule

// File: tb/mw_eeprom_responder_bench.sv
module mw_eeprom_responder_bench;

  localparam int AW    = 6;
  localparam int NW    = 1 << AW;
  localparam int BUSY  = 64;
  localparam int HALF  = 6;

  logic clk, rst_n, cs, sk, di;
  logic dout;
  int   n_checks, n_fails;

  mw_eeprom_responder #(
    .ADDR_W      (AW),
    .DATA_W      (16),
    .BUSY_CYCLES (BUSY),
    .SYNC_STAGES (2)
  ) u_mw_eeprom_responder (
    .clk   (clk),
    .rst_n (rst_n),
    .mw_cs (cs),
    .mw_sk (sk),
    .mw_di (di),
    .mw_do (dout)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int a);
    return 16'hA5C3 ^ (16'(a) * 16'h0403);
  endfunction

  task automatic frame(input int n, input logic [63:0] s, output logic [63:0] outs);
    outs = '0;
    cs = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      di = s[k];
      repeat (HALF) @(negedge clk);
      sk = 1'b1;
      repeat (HALF) @(negedge clk);
      outs[k] = dout;
      sk = 1'b0;
    end
    di = 1'b0;
    repeat (2) @(negedge clk);
    cs = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic cmd(input int lead, input logic [1:0] op, input logic [AW-1:0] a,
                     input logic [15:0] d, input int nd, input int extra,
                     output logic [63:0] outs, output int last_addr);
    logic [63:0] s;
    int p;
    s = '0;
    p = lead;
    s[p] = 1'b1;
    s[p+1] = op[1];
    s[p+2] = op[0];
    p = p + 3;
    for (int i = AW - 1; i >= 0; i--) begin
      s[p] = a[i];
      p++;
    end
    last_addr = p - 1;
    for (int i = 15; i >= 16 - nd; i--) begin
      s[p] = d[i];
      p++;
    end
    frame(p + extra, s, outs);
  endtask

  task automatic read_chk(input logic [AW-1:0] a, input logic [15:0] exp, input string req, input int lead);
    logic [63:0] o;
    int la;
    logic [15:0] got;
    logic pre_ok;
    cmd(lead, 2'b10, a, 16'h0, 0, 17, o, la);
    for (int j = 0; j < 16; j++) got[15-j] = o[la+1+j];
    check(got == exp, req, {16'h0, got}, {16'h0, exp});
    pre_ok = 1'b1;
    for (int k = 0; k <= la; k++) if (o[k]) pre_ok = 1'b0;
    check(pre_ok && !o[la+17], "R3/R11 dummy zero, quiet command phase and tail",
          {30'h0, pre_ok, o[la+17]}, 32'h2);
  endtask

  task automatic prog(input logic [1:0] op, input logic [AW-1:0] a, input logic [15:0] d, input int nd);
    logic [63:0] o;
    int la;
    cmd(0, op, a, d, nd, 0, o, la);
    check(o == '0, "R11 data out low during programming frame", o[31:0], 32'h0);
    repeat (BUSY + 8) @(negedge clk);
  endtask

  initial begin
    n_checks = 0;
    n_fails  = 0;
    #190000000;
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [63:0] o;
    int la;
    rst_n = 1'b0;
    cs = 1'b0;
    sk = 1'b0;
    di = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(dout == 1'b0, "R1 data out low after reset", {31'h0, dout}, 32'h0);

    // R1 erased contents, R2 leading zeros on odd addresses
    for (int a = 0; a < NW; a++)
      read_chk(AW'(a), 16'hFFFF, (a % 2) ? "R2 leading zeros ignored" : "R1 reset word", (a % 2) ? 3 : 0);

    // R6 latch clear after reset: write has no effect
    prog(2'b01, AW'(5), 16'h1357, 16);
    read_chk(AW'(5), 16'hFFFF, "R6 write blocked while latch clear", 0);

    // R6 unlock, then R4 write every word
    prog(2'b00, {2'b11, {(AW-2){1'b0}}}, 16'h0, 0);
    for (int a = 0; a < NW; a++) prog(2'b01, AW'(a), pat(a), 16);
    for (int a = 0; a < NW; a++) read_chk(AW'(a), pat(a), "R4 written word", 0);

    // R5 single erase
    prog(2'b11, AW'(7), 16'h0, 0);
    read_chk(AW'(7), 16'hFFFF, "R5 erased word", 0);
    read_chk(AW'(6), pat(6), "R5 neighbour below kept", 0);
    read_chk(AW'(8), pat(8), "R5 neighbour above kept", 0);

    // R6 lock, then programming ignored
    prog(2'b00, {2'b00, {(AW-2){1'b1}}}, 16'h0, 0);
    prog(2'b11, AW'(6), 16'h0, 0);
    prog(2'b01, AW'(8), 16'h0000, 16);
    prog(2'b00, {2'b10, {(AW-2){1'b0}}}, 16'h0, 0);
    prog(2'b00, {2'b01, {(AW-2){1'b0}}}, 16'h0F0F, 16);
    read_chk(AW'(6), pat(6), "R6 erase blocked after lock", 0);
    read_chk(AW'(8), pat(8), "R6 write blocked after lock", 0);
    read_chk(AW'(40), pat(40), "R6 bulk commands blocked after lock", 0);

    // R8 write-all
    prog(2'b00, {2'b11, {(AW-2){1'b0}}}, 16'h0, 0);
    prog(2'b00, {2'b01, {(AW-2){1'b1}}}, 16'h3C96, 16);
    for (int a = 0; a < NW; a++) read_chk(AW'(a), 16'h3C96, "R8 fill word", 0);

    // R9 write cut short by select low
    cmd(0, 2'b01, AW'(10), 16'h0000, 8, 0, o, la);
    repeat (BUSY + 8) @(negedge clk);
    read_chk(AW'(10), 16'h3C96, "R9 partial write has no effect", 0);

    // R10 read started inside busy window is discarded
    cmd(0, 2'b01, AW'(3), 16'hBEEF, 16, 0, o, la);
    cmd(0, 2'b10, AW'(3), 16'h0, 0, 17, o, la);
    check(o == '0, "R10 frame in busy window discarded", o[31:0], 32'h0);
    repeat (BUSY + 8) @(negedge clk);
    read_chk(AW'(3), 16'hBEEF, "R10 write before busy window landed", 0);

    // R7 erase-all
    prog(2'b00, {2'b10, {(AW-2){1'b1}}}, 16'h0, 0);
    for (int a = 0; a < NW; a++) read_chk(AW'(a), 16'hFFFF, "R7 cleared word", 0);

    // R9 read cut short: data out returns low after select falls
    cmd(0, 2'b10, AW'(12), 16'h0, 0, 3, o, la);
    check(o[la+2] == 1'b1, "R9 read answer was high before abort", {31'h0, o[la+2]}, 32'h1);
    check(dout == 1'b0, "R9 data out low after select falls", {31'h0, dout}, 32'h0);
    read_chk(AW'(12), 16'hFFFF, "R9 new frame after abort", 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule